// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block decodes byte accesses from a host into a 16-byte I/O window that serves two disk channels. Each channel owns an eight-byte slice. The low half of a slice is a group of four control bytes: a command byte, a mode byte that both channels share, a status byte and a per-channel transfer-timing byte. The high half is a 32-bit descriptor-table pointer that the host can read and write one byte at a time. The block does not move data and does not walk descriptor tables. A command write goes out as a one-cycle strobe so that a separate transfer engine can act on it.

The status byte mixes three kinds of bit in one register. Two bits are plain storage. The activity bit follows the engine and cannot be written. The error bit and the interrupt bit are set by engine pulses and cleared by writing a one. The shared mode byte holds one interrupt flag and one interrupt mask per channel. The host can write only the masks, and the block's interrupt output is formed from the flags and masks. Only single-byte accesses reach the registers.

Top module: `bmdma_regwin`

## Requirements
- R1: Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request. `size_i` encodes the width: 0 is a byte, 1 is two bytes, and 2 or 3 is four bytes. A byte read returns the register in bits 7:0 with bits 31:8 at zero. A two-byte read returns 0x0000FFFF and a four-byte read returns 0xFFFFFFFF.
- R2: A write whose `size_i` is not 0 changes no register and produces no command strobe.
- R3: `addr_i[3]` selects the channel. When `addr_i[2]` is 0, `addr_i[1:0]` picks a register in the group: 0 is the command byte, 1 the mode byte, 2 the status byte and 3 the timing byte. When `addr_i[2]` is 1, `addr_i[1:0]` picks a byte of the pointer, with byte 0 holding bits 7:0.
- R4: A byte write to the command byte stores the value and raises `cmd_stb_o` for exactly the following cycle. In that cycle `cmd_data_o` carries the written byte and `cmd_chan_o` the channel. A later read returns the stored value.
- R5: The mode byte is one register that both channels reach at group offset 1. A write changes only bits 5:4, which are the masks for channels 0 and 1. Bits 3:2 take the value of `irq_lvl_i[1:0]` one cycle after it is sampled. All other mode bits read zero.
- R6: `irq_o` is high when the mode byte has bit 2 set with bit 4 clear, or bit 3 set with bit 5 clear.
- R7: A write to the status byte loads bits 6:5 from the data. Status bit 0 takes the value of `eng_act_i` for its channel one cycle after it is sampled, and writes do not change it. Status bits 7, 4 and 3 read zero.
- R8: Status bit 1 (error) is set by `eng_err_set_i` and bit 2 (interrupt) by `eng_int_set_i`. Writing a one to either bit clears it, and writing a zero leaves it unchanged. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: Each channel has its own timing byte at group offset 3, and writing one channel's byte does not change the other channel's.
- R10: Each channel has its own 32-bit pointer. Any byte of it can be written and read back, and the other bytes are unaffected.
- R11: After reset every register is zero, and `rvalid_o`, `cmd_stb_o`, `irq_o` and `rdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 4 | Byte address within the window |
| size_i | input | 2 | Access width: 0 byte, 1 two bytes, 2 or 3 four bytes |
| wdata_i | input | 32 | Write data; a byte write uses bits 7:0 |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| cmd_stb_o | output | 1 | One-cycle command write strobe |
| cmd_data_o | output | 8 | Byte written to the command register |
| cmd_chan_o | output | 1 | Channel of the command write |
| eng_act_i | input | 2 | Per-channel engine activity level |
| eng_err_set_i | input | 2 | Per-channel error set pulse |
| eng_int_set_i | input | 2 | Per-channel interrupt set pulse |
| irq_lvl_i | input | 2 | Per-channel interrupt request level |
| irq_o | output | 1 | Combined interrupt output |

## Verification
Every byte offset of both channels is written with values that differ between the channels and between the bytes of each pointer. This exposes a wrong channel select, a wrong byte lane or storage that the two channels share by mistake. Two-byte and four-byte reads and writes are aimed at registers that already hold known values, so that a wide access that leaks through to a register shows up on readback. Status writes of all ones, of a single bit and of zero are mixed with engine set pulses, including a set in the same cycle as a clear. This separates the plain bits, the read-only bit and the write-one-to-clear bits. Flag and mask patterns on the mode byte cover every masked and unmasked combination of the interrupt output.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORDX = 2'd3
  } acc_size_e;

  // group offset ordering is fixed by the host software view
  typedef enum logic [1:0] {
    GRP_CMD  = 2'd0,
    GRP_MODE = 2'd1,
    GRP_STAT = 2'd2,
    GRP_TIME = 2'd3
  } grp_off_e;

  typedef struct packed {
    logic cmd;
    logic mode;
    logic stat;
    logic timing;
    logic slot;
  } sel_t;

  localparam int STAT_ACT = 0;
  localparam int STAT_ERR = 1;
  localparam int STAT_INT = 2;
  localparam logic [7:0] STAT_RW_MASK  = 8'h60;
  localparam logic [7:0] STAT_W1C_MASK = 8'h06;
  localparam int MODE_INT_LSB = 2;
  localparam int MODE_BLK_LSB = 4;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int CH_W   = 1,
  parameter int ADDR_W = CH_W + 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output sel_t              wr_o,
  output sel_t              rd_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [1:0]        lane_o
);
  logic byte_ok;
  sel_t sel;

  always_comb begin
    byte_ok = req_i && (size_i == ACC_BYTE);
    sel     = '0;
    if (addr_i[2]) begin
      sel.slot = 1'b1;
    end else begin
      unique case (addr_i[1:0])
        GRP_CMD:  sel.cmd    = 1'b1;
        GRP_MODE: sel.mode   = 1'b1;
        GRP_STAT: sel.stat   = 1'b1;
        default:  sel.timing = 1'b1;
      endcase
    end
    wr_o = (byte_ok && we_i)  ? sel : '0;
    rd_o = (byte_ok && !we_i) ? sel : '0;
  end

  assign ch_o   = addr_i[ADDR_W-1:3];
  assign lane_o = addr_i[1:0];
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sel_t              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [1:0]        lane_i,
  input  logic              eng_act_i,
  input  logic              err_set_i,
  input  logic              int_set_i,
  output logic [7:0]        cmd_o,
  output logic [7:0]        stat_o,
  output logic [7:0]        time_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [7:0]        cmd_q, stat_q, stat_d, time_q;
  logic [SLOT_W-1:0] slot_q;
  logic              unused_mode;

  assign unused_mode = wr_i.mode;

  always_comb begin
    stat_d = stat_q;
    if (wr_i.stat)
      stat_d = (wdata_i & STAT_RW_MASK) | (stat_q & ~wdata_i & STAT_W1C_MASK);
    stat_d[STAT_ACT] = eng_act_i;
    // engine set wins over a same-cycle host clear
    if (err_set_i) stat_d[STAT_ERR] = 1'b1;
    if (int_set_i) stat_d[STAT_INT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
      time_q <= '0;
      slot_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_i.cmd)    cmd_q <= wdata_i;
      if (wr_i.timing) time_q <= wdata_i;
      if (wr_i.slot)   slot_q[{lane_i, 3'b000} +: 8] <= wdata_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
  assign time_o = time_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/bmdma_mode.sv
module bmdma_mode
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [NUM_CH-1:0] irq_lvl_i,
  output logic [7:0]        mode_o,
  output logic              irq_o
);
  logic [7:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else begin
      mode_q[MODE_INT_LSB +: NUM_CH] <= irq_lvl_i;
      if (wr_i) mode_q[MODE_BLK_LSB +: NUM_CH] <= wdata_i[MODE_BLK_LSB +: NUM_CH];
    end
  end

  assign mode_o = mode_q;
  assign irq_o  = |(mode_q[MODE_INT_LSB +: NUM_CH] & ~mode_q[MODE_BLK_LSB +: NUM_CH]);
endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int SLOT_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              cmd_stb_o,
  output logic [7:0]        cmd_data_o,
  output logic [CH_W-1:0]   cmd_chan_o,
  input  logic [NUM_CH-1:0] eng_act_i,
  input  logic [NUM_CH-1:0] eng_err_set_i,
  input  logic [NUM_CH-1:0] eng_int_set_i,
  input  logic [NUM_CH-1:0] irq_lvl_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] ONES_HALF = {{(DATA_W-16){1'b0}}, 16'hFFFF};
  localparam logic [DATA_W-1:0] ONES_WORD = '1;

  sel_t              wr_w, rd_w;
  logic [CH_W-1:0]   ch_w;
  logic [1:0]        lane_w;
  logic [7:0]        mode_w;
  logic [7:0]        rd_byte;
  logic              unused_wdata;

  sel_t              ch_wr   [NUM_CH];
  logic [7:0]        cmd_w   [NUM_CH];
  logic [7:0]        stat_w  [NUM_CH];
  logic [7:0]        time_w  [NUM_CH];
  logic [SLOT_W-1:0] slot_w  [NUM_CH];

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q, cmd_stb_q;
  logic [7:0]        cmd_data_q;
  logic [CH_W-1:0]   cmd_chan_q;

  assign unused_wdata = ^wdata_i[DATA_W-1:8];

  bmdma_decode #(.CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .wr_o   (wr_w),
    .rd_o   (rd_w),
    .ch_o   (ch_w),
    .lane_o (lane_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_wr[c] = (ch_w == CH_W'(c)) ? wr_w : '0;

    bmdma_chan #(.SLOT_W(SLOT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ch_wr[c]),
      .wdata_i   (wdata_i[7:0]),
      .lane_i    (lane_w),
      .eng_act_i (eng_act_i[c]),
      .err_set_i (eng_err_set_i[c]),
      .int_set_i (eng_int_set_i[c]),
      .cmd_o     (cmd_w[c]),
      .stat_o    (stat_w[c]),
      .time_o    (time_w[c]),
      .slot_o    (slot_w[c])
    );
  end

  bmdma_mode #(.NUM_CH(NUM_CH)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_w.mode),
    .wdata_i   (wdata_i[7:0]),
    .irq_lvl_i (irq_lvl_i),
    .mode_o    (mode_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_byte = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_w == CH_W'(c)) begin
        if (rd_w.cmd)    rd_byte = cmd_w[c];
        if (rd_w.stat)   rd_byte = stat_w[c];
        if (rd_w.timing) rd_byte = time_w[c];
        if (rd_w.slot)   rd_byte = slot_w[c][{lane_w, 3'b000} +: 8];
      end
    end
    if (rd_w.mode) rd_byte = mode_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      cmd_stb_q  <= 1'b0;
      cmd_data_q <= '0;
      cmd_chan_q <= '0;
    end else begin
      rvalid_q  <= req_i && !we_i;
      cmd_stb_q <= wr_w.cmd;
      if (req_i && !we_i) begin
        if (size_i == ACC_BYTE)      rdata_q <= {{(DATA_W-8){1'b0}}, rd_byte};
        else if (size_i == ACC_HALF) rdata_q <= ONES_HALF;
        else                         rdata_q <= ONES_WORD;
      end
      if (wr_w.cmd) begin
        cmd_data_q <= wdata_i[7:0];
        cmd_chan_q <= ch_w;
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign cmd_stb_o  = cmd_stb_q;
  assign cmd_data_o = cmd_data_q;
  assign cmd_chan_o = cmd_chan_q;
endmodule

// File: rtl/bmdma_regwin_chk.sv
module bmdma_regwin_chk #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              cmd_stb_o,
  input logic [7:0]        cmd_data_o,
  input logic [CH_W-1:0]   cmd_chan_o,
  input logic [NUM_CH-1:0] eng_act_i,
  input logic [NUM_CH-1:0] eng_err_set_i,
  input logic [NUM_CH-1:0] eng_int_set_i,
  input logic [NUM_CH-1:0] irq_lvl_i,
  input logic              irq_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_cmd_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && cmd_stb_o) |-> $past(req_i && we_i && size_i == 2'd0 && addr_i[2:0] == 3'd0));

  assert_cmd_payload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && cmd_stb_o) |-> (cmd_data_o == $past(wdata_i[7:0]) &&
                                cmd_chan_o == $past(addr_i[ADDR_W-1:3])));

  assert_wide_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != 2'd0) |=> !cmd_stb_o);

  assert_rvalid_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && rvalid_o) |-> $past(req_i && !we_i));

  assert_half_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd1) |=> (rdata_o == {{(DATA_W-16){1'b0}}, 16'hFFFF}));

  assert_word_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i[1]) |=> (rdata_o == {DATA_W{1'b1}}));

  assert_byte_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[DATA_W-1:8] == '0));

  assert_irq_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o) |-> ($past(irq_lvl_i) != '0));

  logic unused_chk;
  assign unused_chk = ^{eng_act_i, eng_err_set_i, eng_int_set_i};
endmodule

bind bmdma_regwin bmdma_regwin_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/sim_bmdma_regwin.sv
module sim_bmdma_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  act = '0, err_set = '0, int_set = '0, lvl = '0;
  logic [31:0] rdata;
  logic        rvalid, cmd_stb, cmd_chan, irq;
  logic [7:0]  cmd_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_tag = "R3";

  always #4 clk = ~clk;

  bmdma_regwin u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .cmd_stb_o(cmd_stb), .cmd_data_o(cmd_data), .cmd_chan_o(cmd_chan),
    .eng_act_i(act), .eng_err_set_i(err_set), .eng_int_set_i(int_set),
    .irq_lvl_i(lvl), .irq_o(irq)
  );

  // reference model
  logic [7:0]  m_cmd [2], m_stat [2], m_tim [2];
  logic [31:0] m_slot [2];
  logic [7:0]  m_mode;
  logic [31:0] e_rdata;
  logic        e_rvalid, e_stb, e_chan, e_irq;
  logic [7:0]  e_sdata;
  string       e_rtag;

  function automatic logic [31:0] m_read();
    int c = addr[3];
    if (size == 2'd1) return 32'h0000FFFF;
    if (size >= 2'd2) return 32'hFFFFFFFF;
    if (addr[2]) return (m_slot[c] >> (8 * addr[1:0])) & 32'hFF;
    case (addr[1:0])
      2'd0: return {24'h0, m_cmd[c]};
      2'd1: return {24'h0, m_mode};
      2'd2: return {24'h0, m_stat[c]};
      default: return {24'h0, m_tim[c]};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 0; m_stat[c] = 0; m_tim[c] = 0; m_slot[c] = 0;
      end
      m_mode = 0; e_rdata = 0; e_rvalid = 0; e_stb = 0; e_chan = 0; e_irq = 0; e_sdata = 0;
    end else begin
      logic [7:0] d;
      int c;
      logic [7:0] ns [2];
      d = wdata[7:0];
      c = addr[3];
      e_rvalid = req && !we;
      if (req && !we) begin e_rdata = m_read(); e_rtag = cur_tag; end
      e_stb = 0;
      ns[0] = m_stat[0]; ns[1] = m_stat[1];
      if (req && we && size == 2'd0) begin
        if (addr[2]) m_slot[c][8*addr[1:0] +: 8] = d;
        else case (addr[1:0])
          2'd0: begin m_cmd[c] = d; e_stb = 1; e_sdata = d; e_chan = addr[3]; end
          2'd1: m_mode[5:4] = d[5:4];
          2'd2: ns[c] = (d & 8'h60) | (m_stat[c] & ~d & 8'h06);
          default: m_tim[c] = d;
        endcase
      end
      for (int k = 0; k < 2; k++) begin
        ns[k][0] = act[k];
        if (err_set[k]) ns[k][1] = 1'b1;
        if (int_set[k]) ns[k][2] = 1'b1;
        m_stat[k] = ns[k];
      end
      m_mode[3:2] = lvl;
      e_irq = (m_mode[2] && !m_mode[4]) || (m_mode[3] && !m_mode[5]);
    end
  end

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 rvalid", {31'h0, rvalid}, {31'h0, e_rvalid});
      if (e_rvalid) chk({e_rtag, " rdata"}, rdata, e_rdata);
      chk("R4 cmd_stb", {31'h0, cmd_stb}, {31'h0, e_stb});
      if (e_stb) begin
        chk("R4 cmd_data", {24'h0, cmd_data}, {24'h0, e_sdata});
        chk("R4 cmd_chan", {31'h0, cmd_chan}, {31'h0, e_chan});
      end
      chk("R6 irq", {31'h0, irq}, {31'h0, e_irq});
    end
  end

  task automatic acc(string tag, bit w, logic [3:0] a, logic [1:0] s, logic [31:0] dt);
    @(negedge clk);
    cur_tag = tag; req = 1; we = w; addr = a; size = s; wdata = dt;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rvalid", {31'h0, rvalid}, 32'h0);
    chk("R11 cmd_stb", {31'h0, cmd_stb}, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);
    chk("R11 rdata", rdata, 32'h0);
    rst_n = 1;
    for (int a = 0; a < 16; a++) acc("R11", 0, 4'(a), 0, 0);
    // commands on both channels
    acc("R4", 1, 4'h0, 0, 32'hA5); acc("R4", 1, 4'h8, 0, 32'h3C);
    acc("R4", 0, 4'h0, 0, 0);      acc("R4", 0, 4'h8, 0, 0);
    // timing bytes
    acc("R9", 1, 4'h3, 0, 32'h11); acc("R9", 0, 4'hB, 0, 0);
    acc("R9", 1, 4'hB, 0, 32'h22); acc("R9", 0, 4'h3, 0, 0); acc("R9", 0, 4'hB, 0, 0);
    // pointer bytes
    for (int b = 0; b < 4; b++) acc("R10", 1, 4'(4 + b), 0, 32'(8'h01 + b));
    for (int b = 0; b < 4; b++) acc("R10", 1, 4'(12 + b), 0, 32'(8'hF0 + 3 * b));
    acc("R10", 1, 4'h5, 0, 32'h7E);
    for (int a = 0; a < 16; a++) acc("R3", 0, 4'(a), 0, 0);
    // wide writes ignored
    acc("R2", 1, 4'h0, 1, 32'hFFFF); acc("R2", 1, 4'h3, 2, 32'hFFFFFFFF);
    acc("R2", 1, 4'hC, 3, 32'h12345678); acc("R2", 1, 4'h1, 1, 32'h30);
    acc("R2", 0, 4'h0, 0, 0); acc("R2", 0, 4'h3, 0, 0);
    acc("R2", 0, 4'hC, 0, 0); acc("R2", 0, 4'h1, 0, 0);
    // wide reads
    acc("R1", 0, 4'h0, 1, 0); acc("R1", 0, 4'h4, 2, 0); acc("R1", 0, 4'hB, 3, 0);
    // mode byte and interrupt
    acc("R5", 1, 4'h9, 0, 32'hFF); acc("R5", 0, 4'h1, 0, 0); acc("R5", 0, 4'h9, 0, 0);
    @(negedge clk) lvl = 2'b01;
    acc("R5", 0, 4'h1, 0, 0);
    acc("R6", 1, 4'h1, 0, 32'h00);
    @(negedge clk) lvl = 2'b10;
    acc("R6", 1, 4'h1, 0, 32'h20);
    @(negedge clk) lvl = 2'b11;
    acc("R6", 0, 4'h9, 0, 0);
    acc("R6", 1, 4'h1, 0, 32'h10);
    @(negedge clk) lvl = 2'b00;
    acc("R5", 0, 4'h1, 0, 0);
    // status plain and read-only bits
    @(negedge clk) act = 2'b01;
    acc("R7", 0, 4'h2, 0, 0); acc("R7", 0, 4'hA, 0, 0);
    acc("R7", 1, 4'h2, 0, 32'hFF); acc("R7", 0, 4'h2, 0, 0);
    @(negedge clk) act = 2'b00;
    acc("R7", 1, 4'h2, 0, 32'h01); acc("R7", 0, 4'h2, 0, 0);
    // write-one-to-clear bits
    @(negedge clk) begin err_set = 2'b10; int_set = 2'b10; end
    @(negedge clk) begin err_set = 2'b00; int_set = 2'b00; end
    acc("R8", 0, 4'hA, 0, 0);
    acc("R8", 1, 4'hA, 0, 32'h00); acc("R8", 0, 4'hA, 0, 0);
    acc("R8", 1, 4'hA, 0, 32'h02); acc("R8", 0, 4'hA, 0, 0);
    @(negedge clk);
    cur_tag = "R8"; req = 1; we = 1; addr = 4'hA; size = 0; wdata = 32'h04; int_set = 2'b10;
    @(negedge clk);
    req = 0; we = 0; int_set = 2'b00;
    acc("R8", 0, 4'hA, 0, 0);
    acc("R8", 1, 4'hA, 0, 32'h66); acc("R8", 0, 4'hA, 0, 0); acc("R8", 0, 4'h2, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule